// File: doc/BRIEF.md
# Three-Channel Dead-Time Gate Sequencer

This block turns three pairs of logic-level commands into gate commands for three independent half-bridge power stages. Each channel has a level input that chooses which switch conducts and an enable that can force the whole leg off. For every channel the block drives one upper-switch command and one lower-switch command. Whenever the conducting switch changes, both commands stay low for a fixed number of clock cycles, so the two switches of a leg can never conduct together.

An 8-bit junction-temperature code, in whole degrees Celsius, feeds a shared over-temperature cutoff with hysteresis. Once the trip threshold is reached, every switch of every channel is forced off. Normal drive returns only after the code has fallen to the release threshold. Inputs and enables pass through two-flop synchronizers. The temperature code goes through a matching register pipeline, so all three kinds of stimulus take effect with the same latency. With the default 100 MHz clock and 30-cycle dead time, the gap is 300 ns. Input switching rates up to 50 kHz are far below the rate at which the block can follow its inputs.

Top module: `tri_gate_sequencer`

## Requirements
- R1: While rst_n is low, every gate command is low. After reset is released, no command goes high before DEAD_CYCLES+2 rising edges have passed.
- R2: While a channel's synchronized enable is low, both of that channel's commands are low, whatever its input is.
- R3: With the enable high, input 1 selects the upper command (gateUpper high, gateLower low). Input 0 selects the lower command.
- R4: When the selected switch changes, both commands of that channel are low for exactly DEAD_CYCLES clock cycles before the new command goes high.
- R5: gateUpper[c] and gateLower[c] are never high in the same cycle.
- R6: If the selection changes again while a channel is in its dead time, the dead-time count restarts. Only the command matching the final selection turns on, DEAD_CYCLES cycles after that last change.
- R7: A temperature code greater than or equal to TRIP_C forces every command of every channel low.
- R8: After a trip, the cutoff stays active until the code is less than or equal to RELEASE_C. Codes strictly between the two thresholds leave the cutoff state unchanged.
- R9: When drive resumes after a thermal release or after the enable returns high, the selected command turns on only after a full dead time.
- R10: Each channel's commands depend only on its own input and enable and on the shared cutoff.
- R11: Let edge k be the first rising edge at which a new input, enable or temperature value is present at the pins. Commands that must go low do so at edge k+2. A newly selected command goes high at edge k+2+DEAD_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, default 100 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| legIn | input | CHANNELS | Per-channel selection: 1 = upper switch, 0 = lower switch |
| legEn | input | CHANNELS | Per-channel enable; low turns the leg fully off |
| dieTemp | input | TEMP_W | Unsigned junction-temperature code in °C |
| gateUpper | output | CHANNELS | Upper switch command per channel |
| gateLower | output | CHANNELS | Lower switch command per channel |

## Verification
The bench keeps three channels and the 160/140 °C thresholds, but shortens the dead time to 5 cycles. This makes an exhaustive sweep affordable: every ordered pair of the 64 joint input/enable states is visited, each state held just past one dead time. Every selection change, disable, re-enable and cross-channel combination is therefore reached. The short dead time also lets a sweep of reversal gaps from one cycle to beyond the dead time exercise the counter restart. Temperature ramps through both thresholds, plus bounces inside the hysteresis band, are checked cycle by cycle against an arithmetic window model of the expected commands.

// File: rtl/tri_gate_pkg.sv
package tri_gate_pkg;

  typedef enum logic [1:0] {
    LEG_OFF   = 2'd0,
    LEG_UPPER = 2'd1,
    LEG_LOWER = 2'd2
  } leg_e;

  // Per-channel strobes from control to datapath
  typedef struct packed {
    logic restart;  // selection changed: load leg, clear dead-time count
    logic advance;  // count one more dead-time cycle
    leg_e leg;      // leg to load on restart
  } leg_strobe_t;

endpackage

// File: rtl/tri_gate_sync.sv
module tri_gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tri_gate_ctrl.sv
module tri_gate_ctrl
  import tri_gate_pkg::*;
#(
  parameter int CHANNELS  = 3,
  parameter int TEMP_W    = 8,
  parameter int TRIP_C    = 160,
  parameter int RELEASE_C = 140
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [CHANNELS-1:0]           syncIn,
  input  logic [CHANNELS-1:0]           syncEn,
  input  logic [TEMP_W-1:0]             tempQ,
  input  leg_e [CHANNELS-1:0]           curLeg,
  input  logic [CHANNELS-1:0]           deadDone,
  output leg_strobe_t [CHANNELS-1:0]    strobe
);
  localparam logic [TEMP_W-1:0] TRIP_CODE    = TRIP_C[TEMP_W-1:0];
  localparam logic [TEMP_W-1:0] RELEASE_CODE = RELEASE_C[TEMP_W-1:0];

  logic overTemp;
  leg_e wantLeg [CHANNELS];

  // Hysteretic cutoff shared by all channels
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        overTemp <= 1'b0;
    else if (overTemp) overTemp <= !(tempQ <= RELEASE_CODE);
    else               overTemp <= (tempQ >= TRIP_CODE);
  end

  always_comb begin
    for (int c = 0; c < CHANNELS; c++) begin
      if (overTemp || !syncEn[c]) wantLeg[c] = LEG_OFF;
      else if (syncIn[c])         wantLeg[c] = LEG_UPPER;
      else                        wantLeg[c] = LEG_LOWER;
      strobe[c].leg     = wantLeg[c];
      strobe[c].restart = (wantLeg[c] != curLeg[c]);
      strobe[c].advance = (wantLeg[c] == curLeg[c]) && !deadDone[c];
    end
  end
endmodule

// File: rtl/tri_gate_dp.sv
module tri_gate_dp
  import tri_gate_pkg::*;
#(
  parameter int CHANNELS    = 3,
  parameter int DEAD_CYCLES = 30,
  parameter int TEMP_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CHANNELS-1:0]        legIn,
  input  logic [CHANNELS-1:0]        legEn,
  input  logic [TEMP_W-1:0]          dieTemp,
  input  leg_strobe_t [CHANNELS-1:0] strobe,
  output logic [CHANNELS-1:0]        syncIn,
  output logic [CHANNELS-1:0]        syncEn,
  output logic [TEMP_W-1:0]          tempQ,
  output leg_e [CHANNELS-1:0]        curLeg,
  output logic [CHANNELS-1:0]        deadDone,
  output logic [CHANNELS-1:0]        gateUpper,
  output logic [CHANNELS-1:0]        gateLower
);
  localparam int              CNT_W     = $clog2(DEAD_CYCLES + 1);
  localparam logic [CNT_W-1:0] DEAD_LAST = CNT_W'(DEAD_CYCLES);
  localparam int              TPIPE     = SYNC_STAGES - 1;

  // Temperature pipeline: one stage shorter than the bit synchronizers,
  // since the cutoff flag adds the last register.
  logic [TEMP_W-1:0] tempPipe [TPIPE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TPIPE; i++) tempPipe[i] <= '0;
    end else begin
      tempPipe[0] <= dieTemp;
      for (int i = 1; i < TPIPE; i++) tempPipe[i] <= tempPipe[i-1];
    end
  end

  assign tempQ = tempPipe[TPIPE-1];

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    leg_e             legQ, legD;
    logic [CNT_W-1:0] cntQ, cntD;
    logic             upQ, loQ;

    tri_gate_sync #(.STAGES(SYNC_STAGES)) u_syncIn (
      .clk(clk), .rst_n(rst_n), .d(legIn[c]), .q(syncIn[c]));
    tri_gate_sync #(.STAGES(SYNC_STAGES)) u_syncEn (
      .clk(clk), .rst_n(rst_n), .d(legEn[c]), .q(syncEn[c]));

    always_comb begin
      if (strobe[c].restart) begin
        legD = strobe[c].leg;
        cntD = '0;
      end else if (strobe[c].advance) begin
        legD = legQ;
        cntD = cntQ + 1'b1;
      end else begin
        legD = legQ;
        cntD = cntQ;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        legQ <= LEG_OFF;
        cntQ <= '0;
        upQ  <= 1'b0;
        loQ  <= 1'b0;
      end else begin
        legQ <= legD;
        cntQ <= cntD;
        upQ  <= (legD == LEG_UPPER) && (cntD == DEAD_LAST);
        loQ  <= (legD == LEG_LOWER) && (cntD == DEAD_LAST);
      end
    end

    assign curLeg[c]    = legQ;
    assign deadDone[c]  = (cntQ == DEAD_LAST);
    assign gateUpper[c] = upQ;
    assign gateLower[c] = loQ;
  end
endmodule

// File: rtl/tri_gate_sequencer.sv
module tri_gate_sequencer
  import tri_gate_pkg::*;
#(
  parameter int CHANNELS    = 3,
  parameter int DEAD_CYCLES = 30,
  parameter int TEMP_W      = 8,
  parameter int TRIP_C      = 160,
  parameter int RELEASE_C   = 140,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] legIn,
  input  logic [CHANNELS-1:0] legEn,
  input  logic [TEMP_W-1:0]   dieTemp,
  output logic [CHANNELS-1:0] gateUpper,
  output logic [CHANNELS-1:0] gateLower
);
  leg_strobe_t [CHANNELS-1:0] strobe;
  logic [CHANNELS-1:0]        syncIn, syncEn, deadDone;
  logic [TEMP_W-1:0]          tempQ;
  leg_e [CHANNELS-1:0]        curLeg;

  tri_gate_ctrl #(
    .CHANNELS(CHANNELS), .TEMP_W(TEMP_W),
    .TRIP_C(TRIP_C), .RELEASE_C(RELEASE_C)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .syncIn(syncIn), .syncEn(syncEn),
    .tempQ(tempQ), .curLeg(curLeg), .deadDone(deadDone), .strobe(strobe));

  tri_gate_dp #(
    .CHANNELS(CHANNELS), .DEAD_CYCLES(DEAD_CYCLES),
    .TEMP_W(TEMP_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .legIn(legIn), .legEn(legEn),
    .dieTemp(dieTemp), .strobe(strobe), .syncIn(syncIn), .syncEn(syncEn),
    .tempQ(tempQ), .curLeg(curLeg), .deadDone(deadDone),
    .gateUpper(gateUpper), .gateLower(gateLower));
endmodule

// File: rtl/tri_gate_sequencer_chk.sv
module tri_gate_sequencer_chk #(
  parameter int CHANNELS    = 3,
  parameter int DEAD_CYCLES = 30,
  parameter int TEMP_W      = 8,
  parameter int TRIP_C      = 160
) (
  input logic                clk,
  input logic                rst_n,
  input logic [CHANNELS-1:0] legEn,
  input logic [TEMP_W-1:0]   dieTemp,
  input logic [CHANNELS-1:0] gateUpper,
  input logic [CHANNELS-1:0] gateLower
);
  localparam int               RUN_W     = $clog2(DEAD_CYCLES + 1);
  localparam logic [RUN_W-1:0] RUN_MAX   = RUN_W'(DEAD_CYCLES);
  localparam logic [TEMP_W-1:0] TRIP_CODE = TRIP_C[TEMP_W-1:0];

  for (genvar g = 0; g < CHANNELS; g++) begin : g_chk
    logic [RUN_W-1:0] offRun;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         offRun <= '0;
      else if (gateUpper[g] || gateLower[g]) offRun <= '0;
      else if (offRun != RUN_MAX)         offRun <= offRun + 1'b1;
    end

    p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(gateUpper[g] && gateLower[g]));

    p_disable_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(legEn[g], 3) |-> (!gateUpper[g] && !gateLower[g]));

    p_thermal_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dieTemp, 3) >= TRIP_CODE) |-> (!gateUpper[g] && !gateLower[g]));

    p_dead_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((gateUpper[g] || gateLower[g]) && !$past(gateUpper[g] || gateLower[g]))
        |-> (offRun == RUN_MAX));
  end
endmodule

bind tri_gate_sequencer tri_gate_sequencer_chk #(
  .CHANNELS(CHANNELS), .DEAD_CYCLES(DEAD_CYCLES),
  .TEMP_W(TEMP_W), .TRIP_C(TRIP_C)
) u_chk (
  .clk(clk), .rst_n(rst_n), .legEn(legEn), .dieTemp(dieTemp),
  .gateUpper(gateUpper), .gateLower(gateLower));

// File: tb/tri_gate_sequencer_bench.sv
module tri_gate_sequencer_bench;
  localparam int CH   = 3;
  localparam int DEAD = 5;
  localparam int TW   = 8;
  localparam int TRIP = 160;
  localparam int REL  = 140;
  localparam int HL   = DEAD + 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic [CH-1:0] legIn, legEn;
  logic [TW-1:0] dieTemp;
  logic [CH-1:0] gateUpper, gateLower;

  int checks = 0;
  int fails  = 0;

  // Selection codes used by the model: 0 off, 1 upper, 2 lower
  logic [1:0] hist [CH][HL];
  bit hotM;

  tri_gate_sequencer #(
    .CHANNELS(CH), .DEAD_CYCLES(DEAD), .TEMP_W(TW),
    .TRIP_C(TRIP), .RELEASE_C(REL), .SYNC_STAGES(2)
  ) u_tri_gate_sequencer (
    .clk(clk), .rst_n(rst_n), .legIn(legIn), .legEn(legEn),
    .dieTemp(dieTemp), .gateUpper(gateUpper), .gateLower(gateLower));

  task automatic modelClear();
    hotM = 1'b0;
    for (int c = 0; c < CH; c++)
      for (int k = 0; k < HL; k++) hist[c][k] = 2'd0;
  endtask

  // One rising edge: pin values present at the edge enter the window
  task automatic modelEdge(input logic [CH-1:0] inV, input logic [CH-1:0] enV,
                           input logic [TW-1:0] tp);
    if (hotM) hotM = !(int'(tp) <= REL);
    else      hotM = (int'(tp) >= TRIP);
    for (int c = 0; c < CH; c++) begin
      for (int k = HL - 1; k > 0; k--) hist[c][k] = hist[c][k-1];
      if (hotM || !enV[c]) hist[c][0] = 2'd0;
      else                 hist[c][0] = inV[c] ? 2'd1 : 2'd2;
    end
  endtask

  task automatic tick(input logic [CH-1:0] inV, input logic [CH-1:0] enV,
                      input logic [TW-1:0] tp, input string tag);
    logic [CH-1:0] expU, expL;
    bit steady;
    legIn = inV; legEn = enV; dieTemp = tp;
    @(posedge clk);
    if (!rst_n) modelClear();
    else        modelEdge(inV, enV, tp);
    @(negedge clk);
    for (int c = 0; c < CH; c++) begin
      steady = 1'b1;
      for (int k = 3; k < HL; k++) if (hist[c][k] != hist[c][2]) steady = 1'b0;
      expU[c] = rst_n && steady && (hist[c][2] == 2'd1);
      expL[c] = rst_n && steady && (hist[c][2] == 2'd2);
    end
    checks++;
    if (gateUpper !== expU || gateLower !== expL) begin
      fails++;
      $display("FAIL %s: upper=%b lower=%b expected upper=%b lower=%b",
               tag, gateUpper, gateLower, expU, expL);
    end
    checks++;
    if ((gateUpper & gateLower) != '0) begin
      fails++;
      $display("FAIL R5: overlap upper=%b lower=%b expected no common bit",
               gateUpper, gateLower);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run still active, expected finished");
    summary();
    $finish;
  end

  initial begin
    modelClear();
    rst_n = 1'b0; legIn = '0; legEn = '0; dieTemp = '0;
    @(negedge clk);
    // R1: reset holds everything off even with live inputs
    repeat (4) tick(3'b101, 3'b111, 8'd20, "R1 reset");
    rst_n = 1'b1;
    repeat (DEAD + 6) tick(3'b101, 3'b111, 8'd20, "R1 R11 start-up");

    // R2 R3 R4 R10 R11: every ordered pair of joint states
    for (int a = 0; a < 64; a++) begin
      for (int b = 0; b < 64; b++) begin
        repeat (HL) tick(a[2:0], a[5:3], 8'd25, "R2 R3 R4 R10 R11 sweep");
        repeat (HL) tick(b[2:0], b[5:3], 8'd25, "R2 R3 R4 R9 R10 sweep");
      end
    end

    // R6: reversals at every gap shorter and longer than the dead time
    for (int gap = 1; gap <= DEAD + 2; gap++) begin
      for (int r = 0; r < 4; r++)
        repeat (gap) tick(r[0] ? 3'b011 : 3'b100, 3'b111, 8'd25, "R6 reversal");
      repeat (HL) tick(3'b011, 3'b111, 8'd25, "R6 settle");
    end

    // R7: just below trip keeps drive, trip code cuts it
    repeat (HL) tick(3'b010, 3'b111, 8'd159, "R7 below trip");
    repeat (4) tick(3'b010, 3'b111, 8'd160, "R7 trip");
    // R8: codes inside the band keep the cutoff
    for (int t = 159; t >= 141; t--) tick(3'b010, 3'b111, t[7:0], "R8 band down");
    repeat (3) tick(3'b101, 3'b110, 8'd150, "R8 band inputs");
    // R9: release then full dead time
    repeat (HL + 2) tick(3'b010, 3'b111, 8'd140, "R9 release");
    for (int t = 141; t <= 159; t++) tick(3'b010, 3'b111, t[7:0], "R8 band up");
    // R7 R8 R9: full ramps
    for (int t = 100; t <= 220; t++) repeat (2) tick(3'b110, 3'b111, t[7:0], "R7 ramp up");
    for (int t = 220; t >= 100; t--) repeat (2) tick(3'b001, 3'b111, t[7:0], "R8 R9 ramp down");
    // R7: cutoff during a dead time, R2 with disable in the band
    tick(3'b111, 3'b111, 8'd30, "R7 change");
    repeat (2) tick(3'b111, 3'b111, 8'd200, "R7 during dead time");
    repeat (HL) tick(3'b111, 3'b111, 8'd130, "R9 resume");
    repeat (HL) tick(3'b000, 3'b000, 8'd150, "R2 off");
    repeat (HL) tick(3'b000, 3'b111, 8'd150, "R9 re-enable");

    summary();
    $finish;
  end
endmodule